// File: doc/BRIEF.md
# Paged GPIO Register Bank

This block is a byte-wide register bank through which a host controls six 8-bit open-drain I/O ports. Each pin has an active-low drive: a 1 written to a port bit turns that pin's output-enable on, which pulls the pin low. A 0 releases the pin, and an external pull-up takes it high so it can serve as an input. When the host reads a port, it sees the pin level inverted, after a two-flop synchronizer.

Offsets 0 through 5 hold the ports. Offset 6 holds an interrupt summary and offset 7 holds a control byte, which carries a two-bit page number and six sticky per-port lock bits. The page number selects which register group offsets 8 to 10 reach: nothing, edge polarity, edge enable, or interrupt identification. Ports 0 to 2 can raise interrupts. An enabled pin edge of the chosen direction latches an ID bit, the host clears that bit by writing 1 to it, and a single `irq` output is high while any ID bit is set.

The host side is a plain strobe interface with no back-pressure. A write takes effect on the clock edge where `wr` is high. A read returns its data on `rdata` one cycle after `rd`, and `rdata` then holds that value until the next read.

Top module: `gpio_page_bank`

## Requirements
- R1: After reset, `pin_oe`, `irq` and `rdata` are all zero, and the control byte (offset 7) reads 00h, meaning page 0 with no locks.
- R2: Writing an unlocked port offset n (0..5) sets `pin_oe[8n+7:8n]` to the written byte on the next cycle.
- R3: A read of port n returns the bitwise inverse of `pin_in[8n+7:8n]`, sampled through a two-flop synchronizer.
- R4: Offsets 0 to 7 reach the same registers whatever the page is.
- R5: A write to offset 7 sets the page from bits 7:6 and ORs bits 5:0 into the lock bits. A lock bit stays set until reset. Offset 7 reads back as {page, locks}.
- R6: A write to a locked port leaves that port's value and its `pin_oe` unchanged.
- R7: At offsets 8 to 10, register group k = offset-8 maps by page: page 1 reaches polarity k, page 2 reaches enable k, page 3 reaches ID k. Page 0 at these offsets, and every offset from 11 to 15, reads 00h and ignores writes.
- R8: ID bit b of port k (k = 0..2) sets when enable bit b is 1 and the synchronized pin shows a rising edge with polarity bit b = 1, or a falling edge with polarity bit b = 0. A pin whose enable bit is 0 sets nothing.
- R9: Writing 1 to an ID bit clears it, and writing 0 leaves it alone. If an edge capture and a clear land on the same bit in the same cycle, the bit ends up set.
- R10: Offset 6 reads {5'b0, |ID2, |ID1, |ID0} and ignores writes. `irq` equals the OR of all ID bits.
- R11: `rdata` changes only in the cycle after a cycle with `rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid the cycle after `rd` |
| pin_in | input | 48 | Pad input levels, port n at bits 8n+7:8n |
| pin_oe | output | 48 | Pad pull-low enables, 1 drives the pin low |
| irq | output | 1 | OR of all interrupt ID bits |

## Verification
The case hardest to reach from the ports is a pin edge that reaches the ID register in the very cycle the host clears that bit. The edge takes three flops to arrive (two synchronizer stages and the previous-level register), so it has to be launched exactly two cycles before the write strobe. The bench times an external pin change to land on a clear that targets both the incoming bit and another set bit. It expects the incoming bit to survive and the other bit to clear. Random traffic then mixes writes, reads, page changes, occasional locks and pad toggles, and checks each result against a bench model.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpb_irq_port.sv
module gpb_irq_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         pol_we,
  input  logic         en_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] id_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  // edge of the selected direction on an enabled bit
  always_comb begin
    hit = en_q & ((pol_q & lvl & ~prev_q) | (~pol_q & ~lvl & prev_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      id_q   <= '0;
    end else begin
      prev_q <= lvl;
      if (pol_we) pol_q <= wdata;
      if (en_we)  en_q  <= wdata;
      // capture has priority over a simultaneous clear
      id_q <= (clr_we ? (id_q & ~wdata) : id_q) | hit;
    end
  end
endmodule

// File: rtl/gpio_page_bank.sv
module gpio_page_bank #(
  parameter int unsigned NPORTS = 6,
  parameter int unsigned NIRQ   = 3,
  parameter int unsigned AW     = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [AW-1:0]                   addr,
  input  logic [gpb_pkg::BYTE_W-1:0]      wdata,
  input  logic                            wr,
  input  logic                            rd,
  output logic [gpb_pkg::BYTE_W-1:0]      rdata,
  input  logic [NPORTS*gpb_pkg::BYTE_W-1:0] pin_in,
  output logic [NPORTS*gpb_pkg::BYTE_W-1:0] pin_oe,
  output logic                            irq
);
  import gpb_pkg::*;

  localparam int unsigned BW       = BYTE_W;
  localparam int unsigned OFS_PEND = NPORTS;
  localparam int unsigned OFS_CTRL = NPORTS + 1;
  localparam int unsigned OFS_GRP  = NPORTS + 2;

  logic [NPORTS-1:0][BW-1:0] port_q;
  logic [NPORTS-1:0]         lock_q;
  page_e                     page_q;
  logic [NPORTS*BW-1:0]      lvl_s;
  logic [NIRQ*BW-1:0]        pol_all, en_all, id_all;
  logic [NIRQ-1:0]           pol_we, en_we, clr_we;
  logic [BW-1:0]             rd_val;

  gpb_sync #(.W(NPORTS*BW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_s)
  );

  // port and control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      lock_q <= '0;
      page_q <= PG_NONE;
    end else if (wr) begin
      for (int i = 0; i < NPORTS; i++) begin
        if (addr == AW'(i) && !lock_q[i]) port_q[i] <= wdata;
      end
      if (addr == AW'(OFS_CTRL)) begin
        page_q <= page_e'(wdata[BW-1 -: 2]);
        lock_q <= lock_q | wdata[NPORTS-1:0];
      end
    end
  end

  assign pin_oe = port_q;

  // paged interrupt groups
  for (genvar k = 0; k < NIRQ; k++) begin : g_irq
    logic sel;
    assign sel       = wr && (addr == AW'(OFS_GRP + k));
    assign pol_we[k] = sel && (page_q == PG_POL);
    assign en_we[k]  = sel && (page_q == PG_EN);
    assign clr_we[k] = sel && (page_q == PG_ID);

    gpb_irq_port #(.W(BW)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_s[k*BW +: BW]),
      .pol_we(pol_we[k]),
      .en_we (en_we[k]),
      .clr_we(clr_we[k]),
      .wdata (wdata),
      .pol_q (pol_all[k*BW +: BW]),
      .en_q  (en_all[k*BW +: BW]),
      .id_q  (id_all[k*BW +: BW])
    );
  end

  assign irq = |id_all;

  // read decode
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (addr == AW'(i)) rd_val = ~lvl_s[i*BW +: BW];
    end
    if (addr == AW'(OFS_PEND)) begin
      for (int k = 0; k < NIRQ; k++) rd_val[k] = |id_all[k*BW +: BW];
    end
    if (addr == AW'(OFS_CTRL)) begin
      rd_val = '0;
      rd_val[BW-1 -: 2]    = page_q;
      rd_val[NPORTS-1:0]   = lock_q;
    end
    for (int k = 0; k < NIRQ; k++) begin
      if (addr == AW'(OFS_GRP + k)) begin
        case (page_q)
          PG_POL:  rd_val = pol_all[k*BW +: BW];
          PG_EN:   rd_val = en_all[k*BW +: BW];
          PG_ID:   rd_val = id_all[k*BW +: BW];
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_val;
  end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
  parameter int unsigned NPORTS = 6,
  parameter int unsigned NIRQ   = 3,
  parameter int unsigned AW     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        addr,
  input logic [7:0]           wdata,
  input logic                 wr,
  input logic                 rd,
  input logic [7:0]           rdata,
  input logic [NPORTS*8-1:0]  pin_oe,
  input logic                 irq,
  input logic [NPORTS-1:0]    lock_q,
  input logic [NIRQ*8-1:0]    en_all,
  input logic [NIRQ*8-1:0]    id_all
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    AST_PORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AW'(i) && !lock_q[i]) |=> pin_oe[i*8 +: 8] == $past(wdata)); // R2
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> $stable(pin_oe[i*8 +: 8])); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> lock_q[i]); // R5
  end

  for (genvar b = 0; b < NIRQ*8; b++) begin : g_id
    AST_ID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_all[b]) |-> $past(en_all[b])); // R8
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R11
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_all == '0) |-> !irq); // R10
endmodule

bind gpio_page_bank gpb_checker #(.NPORTS(NPORTS), .NIRQ(NIRQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
  .rdata(rdata), .pin_oe(pin_oe), .irq(irq), .lock_q(lock_q),
  .en_all(en_all), .id_all(id_all)
);

// File: tb/tb_gpio_page_bank.sv
`timescale 1ns/1ps
module tb_gpio_page_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 0, rd = 0;
  logic [7:0]  rdata;
  logic [47:0] pin_in, pin_oe, ext_low = '0;
  logic        irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  assign pin_in = ~(pin_oe | ext_low);

  gpio_page_bank dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .irq(irq));

  logic [7:0] m_port[6];
  logic [5:0] m_lock;
  logic [1:0] m_page;
  logic [7:0] m_pol[3], m_en[3], m_id[3];

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mlevel();
    logic [47:0] l;
    for (int p = 0; p < 6; p++) l[p*8 +: 8] = ~(m_port[p] | ext_low[p*8 +: 8]);
    return l;
  endfunction

  function automatic logic [7:0] mread(input logic [3:0] a);
    logic [47:0] l = mlevel();
    if (a < 6) return ~l[a*8 +: 8];
    if (a == 6) return {5'b0, |m_id[2], |m_id[1], |m_id[0]};
    if (a == 7) return {m_page, m_lock};
    if (a >= 8 && a <= 10) begin
      case (m_page)
        2'd1: return m_pol[a-8];
        2'd2: return m_en[a-8];
        2'd3: return m_id[a-8];
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  function automatic logic [47:0] mport_flat();
    logic [47:0] f;
    for (int p = 0; p < 6; p++) f[p*8 +: 8] = m_port[p];
    return f;
  endfunction

  task automatic settle_edges(input logic [47:0] old_l);
    logic [47:0] new_l;
    repeat (4) @(negedge clk);
    new_l = mlevel();
    for (int k = 0; k < 3; k++) begin
      logic [7:0] o = old_l[k*8 +: 8], n = new_l[k*8 +: 8];
      m_id[k] |= m_en[k] & ((m_pol[k] & n & ~o) | (~m_pol[k] & ~n & o));
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    logic [47:0] old_l = mlevel();
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
    if (a < 6) begin
      if (!m_lock[a]) m_port[a] = d;
    end else if (a == 7) begin
      m_page = d[7:6]; m_lock |= d[5:0];
    end else if (a >= 8 && a <= 10) begin
      case (m_page)
        2'd1: m_pol[a-8] = d;
        2'd2: m_en[a-8] = d;
        2'd3: m_id[a-8] &= ~d;
        default: ;
      endcase
    end
    settle_edges(old_l);
  endtask

  task automatic set_ext(input logic [47:0] v);
    logic [47:0] old_l = mlevel();
    ext_low = v;
    settle_edges(old_l);
  endtask

  task automatic do_read(input logic [3:0] a, input string tag);
    logic [7:0] e = mread(a);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0;
    check(rdata == e, tag, rdata, e);
  endtask

  task automatic chk_outs(input string tag);
    logic [47:0] ep = mport_flat();
    logic ei = |{m_id[0], m_id[1], m_id[2]};
    check(pin_oe == ep, {tag, " pin_oe"}, pin_oe, ep);
    check(irq == ei, {tag, " irq"}, irq, ei);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int p = 0; p < 6; p++) m_port[p] = '0;
    for (int k = 0; k < 3; k++) begin m_pol[k] = '0; m_en[k] = '0; m_id[k] = '0; end
    m_lock = '0; m_page = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(pin_oe == 0, "R1 pin_oe", pin_oe, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(rdata == 0, "R1 rdata", rdata, 0);
    do_read(4'h7, "R1 ctrl");
    // R2 / R3 drive and inverted read
    do_write(4'h0, 8'hA5);
    check(pin_oe[7:0] == 8'hA5, "R2 port0 drive", pin_oe[7:0], 8'hA5);
    do_read(4'h0, "R3 port0 read");
    set_ext(48'h0000_0000_0F00);
    do_read(4'h1, "R3 port1 external low");
    // R4 page independence of low offsets
    do_write(4'h7, 8'hC0);
    do_read(4'h0, "R4 port0 on page3");
    do_read(4'h7, "R4 ctrl on page3");
    // R7 reserved and unused offsets
    do_write(4'h7, 8'h00);
    do_write(4'h9, 8'h5A);
    do_read(4'h8, "R7 page0 reserved");
    do_read(4'hC, "R7 unused offset");
    do_write(4'h7, 8'h40);
    do_read(4'h9, "R7 page0 write ignored");
    // R8 edge capture on port2
    do_write(4'hA, 8'h01);
    do_write(4'h7, 8'h80);
    do_write(4'hA, 8'h03);
    set_ext(ext_low | 48'h01_0000);
    do_write(4'h7, 8'hC0);
    do_read(4'hA, "R8 falling not selected");
    set_ext(ext_low & ~48'h01_0000);
    set_ext(ext_low | 48'h02_0000);
    set_ext(ext_low | 48'h04_0000);
    do_read(4'hA, "R8 rise and fall captured");
    check(m_id[2] == 8'h03, "R8 model", m_id[2], 8'h03);
    do_read(4'h6, "R10 pending");
    chk_outs("R10");
    // R9 clear and collision
    do_write(4'hA, 8'h01);
    do_read(4'hA, "R9 w1c");
    set_ext(ext_low | 48'h01_0000);
    @(negedge clk);
    ext_low = ext_low & ~48'h01_0000;
    @(negedge clk);
    @(negedge clk);
    addr = 4'hA; wdata = 8'h03; wr = 1;
    @(negedge clk);
    wr = 0;
    m_id[2] = 8'h01;
    repeat (4) @(negedge clk);
    do_read(4'hA, "R9 capture beats clear");
    // R5 / R6 lock
    do_write(4'h7, 8'hC1);
    do_write(4'h0, 8'h00);
    check(pin_oe[7:0] == 8'hA5, "R6 locked port", pin_oe[7:0], 8'hA5);
    do_write(4'h7, 8'hC0);
    do_read(4'h7, "R5 sticky lock");
    // R11 hold
    do_read(4'h1, "R11 read");
    hold = rdata;
    set_ext(ext_low ^ 48'h00FF_0000_FF00);
    check(rdata == hold, "R11 rdata held", rdata, hold);
    // random phase
    for (int it = 0; it < 400; it++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [3:0] a = 4'($urandom_range(0, 15));
        if (a == 7) do_write(a, {2'($urandom_range(0, 3)),
                                 ($urandom_range(0, 7) == 0) ? 6'(1 << $urandom_range(0, 5)) : 6'd0});
        else do_write(a, 8'($urandom));
      end else if (op < 7) begin
        do_read(4'($urandom_range(0, 15)), "R7 random read");
      end else begin
        set_ext({16'($urandom), 32'($urandom)});
      end
      chk_outs("R2 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule